// File: doc/BRIEF.md
# Flash Self-Write Controller with Holding Latches

This block lets a processor erase and reprogram a small on-chip flash array through a byte-wide register port. A 22-bit table pointer addresses the array. Table accesses through four register addresses leave the pointer unchanged, or move it after the access, or before it. A table write never touches the array. It fills one of eight holding latches, and the latch is picked by the three low pointer bits. A later commit copies all eight latches into the 8-byte group that the upper pointer bits select. An erase sets a 64-byte aligned row back to 0xFF.

An operation starts only after a two-byte key is written to the unlock register and the very next write sets the start bit with write-enable set. Flash timing is reduced to programmable cycle counts. While an operation runs, the controller holds `busy` and rejects table writes and new starts. On completion it pulses `done` and resets the latches to 0xFF. The latch index and the commit address are different slices of one pointer that moves on its own. The order of pointer adjustments around a commit therefore decides where the data lands: it can be rotated by one latch, or it can land in the neighbouring group.

Top module: `flash_selfwrite_ctrl`

## Requirements
- R1: After reset the pointer is 0, the control register reads 0, `busy`, `done` and `wr_error` are 0, every array byte reads 0xFF and every latch holds 0xFF.
- R2: Register map: addresses 0, 1 and 2 hold pointer bits [7:0], [15:8] and [21:16]. Address 3 is control/status: bit0 write-enable, bit1 erase-select, bit2 start (reads 1 while busy), bit3 write-error (write 1 to clear). Address 4 is the unlock register. Addresses 8 to 11 are table accesses with modes plain (8), post-increment (9), post-decrement (10) and pre-increment (11). A table read returns the array byte at the accessed address. Pre-increment accesses pointer+1. Every table access leaves the pointer per its mode, wrapping at 22 bits.
- R3: A table write stores its byte in latch pointer[2:0] (pointer+1 for pre-increment) and leaves the array unchanged.
- R4: Writing 0x55 and then 0xAA to the unlock register, followed directly by a control write with bit2 and bit0 set, starts an operation.
- R5: A key write other than 0xAA after 0x55 breaks the sequence and sets `wr_error`. So does any write other than a valid start after 0xAA, or a start request without the unlock. None of these starts an operation.
- R6: A start request with write-enable (bit0) clear, sent after a full unlock, is ignored and sets `wr_error`.
- R7: With erase-select set at the start, the 64 bytes of the row at pointer[AW-1:6] become 0xFF. No other byte changes.
- R8: A commit ANDs latch j into array byte {pointer[AW-1:3], j}, using the pointer at the start. A bit that is 0 stays 0.
- R9: `busy` is high for exactly ERASE_CYCLES (erase) or PROG_CYCLES (commit) cycles. `done` is high for the single cycle after `busy` falls.
- R10: When an operation completes, all latches return to 0xFF.
- R11: While busy, table writes change neither the latches nor the pointer. Unlock and control writes are ignored and do not restart or lengthen the operation.
- R12: A post-increment from latch index 7 carries into the next group. A post-decrement before eight post-incremented writes puts the first byte in latch 7 and the rest in latches 0 to 6.
- R13: The array byte used is pointer modulo ARRAY_BYTES; higher pointer bits alias.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (moves the pointer on table reads) |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| wr_error | output | 1 | Sticky unlock/start error flag |

## Verification
The bench builds the controller with a 512-byte array, a 20-cycle erase and a 5-cycle commit. The small array lets pointer values above bit 8 exercise aliasing and 22-bit wrap with few writes. The short timings allow many random commit rounds and leave room to inject table, unlock and control writes inside one erase window. The rotated and neighbouring-group landings are directed cases at the 0x40 and 0x80 rows.

// File: rtl/fsw_pkg.sv
package fsw_pkg;
  localparam int PTR_W = 22;
  localparam int NLAT = 8;

  typedef enum logic [1:0] {
    TM_PLAIN   = 2'd0,
    TM_POSTINC = 2'd1,
    TM_POSTDEC = 2'd2,
    TM_PREINC  = 2'd3
  } tbl_mode_e;

  typedef enum logic [1:0] {
    UL_IDLE  = 2'd0,
    UL_GOT55 = 2'd1,
    UL_ARMED = 2'd2
  } ul_state_e;

  localparam logic [7:0] KEY_FIRST  = 8'h55;
  localparam logic [7:0] KEY_SECOND = 8'hAA;

  localparam logic [3:0] RA_PTR0 = 4'd0;
  localparam logic [3:0] RA_PTR1 = 4'd1;
  localparam logic [3:0] RA_PTR2 = 4'd2;
  localparam logic [3:0] RA_CTRL = 4'd3;
  localparam logic [3:0] RA_KEY  = 4'd4;

  // address actually touched by a table access
  function automatic logic [PTR_W-1:0] ptr_access(input logic [PTR_W-1:0] p,
                                                  input tbl_mode_e m);
    return (m == TM_PREINC) ? p + PTR_W'(1) : p;
  endfunction

  // pointer value left behind by a table access
  function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p,
                                                input tbl_mode_e m);
    case (m)
      TM_POSTINC, TM_PREINC: return p + PTR_W'(1);
      TM_POSTDEC:            return p - PTR_W'(1);
      default:               return p;
    endcase
  endfunction
endpackage

// File: rtl/fsw_unlock.sv
module fsw_unlock
  import fsw_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       busy,
  input  logic       key_wr,
  input  logic [7:0] key_data,
  input  logic       ctrl_wr,
  input  logic       ctrl_start,
  input  logic       ctrl_wren,
  input  logic       ctrl_errclr,
  input  logic       other_wr,
  output logic       op_start,
  output logic       werr
);
  ul_state_e st_q, st_d;
  logic      err_set;

  always_comb begin
    st_d     = st_q;
    op_start = 1'b0;
    err_set  = 1'b0;
    if (!busy) begin
      case (st_q)
        UL_IDLE: begin
          if (key_wr && key_data == KEY_FIRST) st_d = UL_GOT55;
          else if (ctrl_wr && ctrl_start)      err_set = 1'b1;
        end
        UL_GOT55: begin
          if (key_wr) begin
            if (key_data == KEY_SECOND) st_d = UL_ARMED;
            else begin
              st_d    = UL_IDLE;
              err_set = 1'b1;
            end
          end else if (ctrl_wr && ctrl_start) begin
            st_d    = UL_IDLE;
            err_set = 1'b1;
          end
        end
        UL_ARMED: begin
          if (ctrl_wr && ctrl_start && ctrl_wren) begin
            op_start = 1'b1;
            st_d     = UL_IDLE;
          end else if (key_wr || ctrl_wr || other_wr) begin
            st_d    = UL_IDLE;
            err_set = 1'b1;
          end
        end
        default: st_d = UL_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= UL_IDLE;
      werr <= 1'b0;
    end else begin
      st_q <= st_d;
      if (err_set)                         werr <= 1'b1;
      else if (ctrl_wr && ctrl_errclr && !busy) werr <= 1'b0;
    end
  end

  AST_ARM_AFTER_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == UL_ARMED) |-> $past(key_wr && key_data == KEY_SECOND)) else $error("arm"); // R4
  AST_BREAK_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == UL_GOT55 && key_wr && key_data != KEY_SECOND && !busy) |=> werr) else $error("brk"); // R5
  AST_NOWREN_SETS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == UL_ARMED && ctrl_wr && ctrl_start && !ctrl_wren && !busy) |=> (werr && st_q == UL_IDLE)) else $error("nowren"); // R6
endmodule

// File: rtl/fsw_pointer.sv
module fsw_pointer
  import fsw_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       byte_wr,
  input  logic [7:0]       wdata,
  input  logic             tbl_go,
  input  tbl_mode_e        tbl_mode,
  output logic [PTR_W-1:0] ptr,
  output logic [AW-1:0]    eff
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptr <= '0;
    else if (tbl_go) ptr <= ptr_next(ptr, tbl_mode);
    else begin
      if (byte_wr[0]) ptr[7:0]   <= wdata;
      if (byte_wr[1]) ptr[15:8]  <= wdata;
      if (byte_wr[2]) ptr[21:16] <= wdata[5:0];
    end
  end

  assign eff = AW'(ptr_access(ptr, tbl_mode));

  AST_PTR_POSTINC: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_go && tbl_mode == TM_POSTINC) |=> ptr == PTR_W'($past(ptr) + PTR_W'(1))) else $error("pinc"); // R12
  AST_PTR_POSTDEC: assert property (@(posedge clk) disable iff (!rst_n)
    (tbl_go && tbl_mode == TM_POSTDEC) |=> ptr == PTR_W'($past(ptr) - PTR_W'(1))) else $error("pdec"); // R2
endmodule

// File: rtl/fsw_latches.sv
module fsw_latches
  import fsw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_go,
  input  logic [2:0]        idx,
  input  logic [7:0]        data,
  input  logic              clear,
  output logic [8*NLAT-1:0] lat_flat
);
  for (genvar i = 0; i < NLAT; i++) begin : g_lat
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         lat_flat[8*i +: 8] <= 8'hFF;
      else if (clear)                     lat_flat[8*i +: 8] <= 8'hFF;
      else if (wr_go && idx == 3'(i))     lat_flat[8*i +: 8] <= data;
    end
  end

  AST_LAT_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (lat_flat == '1)) else $error("latclr"); // R10
  AST_LAT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_go && !clear) |=> $stable(lat_flat)) else $error("lathold"); // R3
endmodule

// File: rtl/fsw_array.sv
module fsw_array
  import fsw_pkg::*;
#(
  parameter int ARRAY_BYTES  = 2048,
  parameter int ERASE_CYCLES = 24,
  parameter int PROG_CYCLES  = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     op_start,
  input  logic                     op_erase,
  input  logic [$clog2(ARRAY_BYTES)-1:0] op_ptr,
  input  logic [$clog2(ARRAY_BYTES)-1:0] rd_addr,
  input  logic [8*NLAT-1:0]        lat_flat,
  output logic [7:0]               rd_data,
  output logic                     busy,
  output logic                     done,
  output logic                     finish
);
  localparam int AW   = $clog2(ARRAY_BYTES);
  localparam int MAXC = (ERASE_CYCLES > PROG_CYCLES) ? ERASE_CYCLES : PROG_CYCLES;
  localparam int CW   = $clog2(MAXC + 1);

  logic [7:0]    mem [ARRAY_BYTES];
  logic [CW-1:0] cnt;
  logic          erase_q;
  logic [AW-1:0] addr_q;

  assign finish  = busy && (cnt == '0);
  assign rd_data = mem[rd_addr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      cnt     <= '0;
      erase_q <= 1'b0;
      addr_q  <= '0;
    end else begin
      done <= finish;
      if (op_start && !busy) begin
        busy    <= 1'b1;
        cnt     <= op_erase ? CW'(ERASE_CYCLES - 1) : CW'(PROG_CYCLES - 1);
        erase_q <= op_erase;
        addr_q  <= op_ptr;
      end else if (busy) begin
        if (cnt == '0) busy <= 1'b0;
        else           cnt  <= cnt - CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < ARRAY_BYTES; i++) mem[i] <= 8'hFF;
    end else if (finish) begin
      if (erase_q) begin
        for (int j = 0; j < 64; j++) mem[{addr_q[AW-1:6], 6'(j)}] <= 8'hFF;
      end else begin
        for (int j = 0; j < NLAT; j++)
          mem[{addr_q[AW-1:3], 3'(j)}] <= mem[{addr_q[AW-1:3], 3'(j)}] & lat_flat[8*j +: 8];
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("donepulse"); // R9
  AST_FALL_GIVES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done) else $error("falldone"); // R9
  AST_NO_START_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !op_start) else $error("busystart"); // R11
endmodule

// File: rtl/flash_selfwrite_ctrl.sv
module flash_selfwrite_ctrl
  import fsw_pkg::*;
#(
  parameter int ARRAY_BYTES  = 2048,
  parameter int ERASE_CYCLES = 24,
  parameter int PROG_CYCLES  = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic       rd_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rdata,
  output logic       busy,
  output logic       done,
  output logic       wr_error
);
  localparam int AW = $clog2(ARRAY_BYTES);

  logic             tbl_sel, tbl_wr_go, tbl_rd_go, tbl_go;
  logic             key_wr, ctrl_wr, other_wr, op_start, finish;
  logic [2:0]       byte_wr;
  logic             wren_q, esel_q;
  logic [PTR_W-1:0] ptr;
  logic [AW-1:0]    eff;
  logic [7:0]       arr_data;
  logic [8*NLAT-1:0] lat_flat;
  tbl_mode_e        tbl_mode;

  assign tbl_sel   = (addr[3:2] == 2'b10);
  assign tbl_mode  = tbl_mode_e'(addr[1:0]);
  assign tbl_wr_go = wr_en && tbl_sel && !busy;
  assign tbl_rd_go = rd_en && !wr_en && tbl_sel;
  assign tbl_go    = tbl_wr_go || tbl_rd_go;
  assign key_wr    = wr_en && (addr == RA_KEY);
  assign ctrl_wr   = wr_en && (addr == RA_CTRL);
  assign other_wr  = wr_en && !key_wr && !ctrl_wr;
  assign byte_wr   = {wr_en && addr == RA_PTR2, wr_en && addr == RA_PTR1, wr_en && addr == RA_PTR0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wren_q <= 1'b0;
      esel_q <= 1'b0;
    end else if (ctrl_wr && !busy) begin
      wren_q <= wdata[0];
      esel_q <= wdata[1];
    end
  end

  fsw_unlock u_unlock (
    .clk(clk), .rst_n(rst_n), .busy(busy),
    .key_wr(key_wr), .key_data(wdata),
    .ctrl_wr(ctrl_wr), .ctrl_start(wdata[2]), .ctrl_wren(wdata[0]),
    .ctrl_errclr(wdata[3]), .other_wr(other_wr),
    .op_start(op_start), .werr(wr_error)
  );

  fsw_pointer #(.AW(AW)) u_ptr (
    .clk(clk), .rst_n(rst_n), .byte_wr(byte_wr), .wdata(wdata),
    .tbl_go(tbl_go), .tbl_mode(tbl_mode), .ptr(ptr), .eff(eff)
  );

  fsw_latches u_lat (
    .clk(clk), .rst_n(rst_n), .wr_go(tbl_wr_go), .idx(eff[2:0]),
    .data(wdata), .clear(finish), .lat_flat(lat_flat)
  );

  fsw_array #(.ARRAY_BYTES(ARRAY_BYTES), .ERASE_CYCLES(ERASE_CYCLES),
              .PROG_CYCLES(PROG_CYCLES)) u_arr (
    .clk(clk), .rst_n(rst_n), .op_start(op_start), .op_erase(wdata[1]),
    .op_ptr(ptr[AW-1:0]), .rd_addr(eff), .lat_flat(lat_flat),
    .rd_data(arr_data), .busy(busy), .done(done), .finish(finish)
  );

  always_comb begin
    case (addr)
      RA_PTR0: rdata = ptr[7:0];
      RA_PTR1: rdata = ptr[15:8];
      RA_PTR2: rdata = {2'b00, ptr[21:16]};
      RA_CTRL: rdata = {4'b0000, wr_error, busy, esel_q, wren_q};
      default: rdata = tbl_sel ? arr_data : 8'h00;
    endcase
  end

  AST_START_GOES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    op_start |=> busy) else $error("startbusy"); // R4
  AST_BUSY_TBL_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && wr_en && tbl_sel) |=> ($stable(ptr) && $stable(lat_flat))) else $error("tblblock"); // R11
endmodule

// File: tb/flash_selfwrite_ctrl_tb.sv
module flash_selfwrite_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 512;
  localparam int EC = 20;
  localparam int PC = 5;

  logic clk = 0, rst_n = 0, wr_en = 0, rd_en = 0;
  logic [3:0] addr = 0;
  logic [7:0] wdata = 0;
  logic [7:0] rdata;
  logic busy, done, wr_error;

  int errors = 0, checks = 0;
  logic [7:0]  mem_m [NB];
  logic [7:0]  lat_m [8];
  logic [21:0] ptr_m;

  flash_selfwrite_ctrl #(.ARRAY_BYTES(NB), .ERASE_CYCLES(EC), .PROG_CYCLES(PC)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .busy(busy), .done(done), .wr_error(wr_error));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [21:0] m_acc(logic [21:0] p, int m);
    return (m == 3) ? p + 22'd1 : p;
  endfunction
  function automatic logic [21:0] m_nxt(logic [21:0] p, int m);
    if (m == 1 || m == 3) return p + 22'd1;
    if (m == 2) return p - 22'd1;
    return p;
  endfunction
  function automatic int m_idx(logic [21:0] p);
    return int'(p) % NB;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic bus_wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1; addr = a; wdata = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic read_reg(logic [3:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1 d = rdata;
  endtask

  task automatic set_ptr(logic [21:0] p);
    bus_wr(0, p[7:0]); bus_wr(1, p[15:8]); bus_wr(2, {2'b0, p[21:16]});
    ptr_m = p;
  endtask

  task automatic tw(int m, logic [7:0] d);
    lat_m[m_acc(ptr_m, m) % 8] = d;
    ptr_m = m_nxt(ptr_m, m);
    bus_wr(4'(8 + m), d);
  endtask

  task automatic tr(int m, string tag);
    @(negedge clk); rd_en = 1; addr = 4'(8 + m);
    #1 check(tag, rdata, mem_m[m_idx(m_acc(ptr_m, m))]);
    @(negedge clk); rd_en = 0;
    ptr_m = m_nxt(ptr_m, m);
  endtask

  task automatic peek(logic [21:0] p, string tag);
    set_ptr(p);
    @(negedge clk); addr = 4'd8; #1 check(tag, rdata, mem_m[m_idx(p)]);
  endtask

  task automatic run_op(bit erase, bit intrude);
    int n; int base; logic [21:0] p0; logic [7:0] d;
    p0 = ptr_m;
    bus_wr(4, 8'h55); bus_wr(4, 8'hAA);
    @(negedge clk); wr_en = 1; addr = 3; wdata = {5'b0, 1'b1, erase, 1'b1};
    @(negedge clk); wr_en = 0;
    #1 check("R9 start bit reads 1 while busy", rdata[2], 1);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      if (intrude) begin
        case (n)
          1: begin wr_en = 1; addr = 9;  wdata = 8'h00; end
          2: begin addr = 4; wdata = 8'h55; end
          3: wdata = 8'hAA;
          4: begin addr = 3; wdata = 8'h07; end
          default: begin wr_en = 0; addr = 3; end
        endcase
      end
      @(negedge clk);
    end
    wr_en = 0;
    check(erase ? "R9 erase busy length" : "R9 commit busy length", n, erase ? EC : PC);
    check("R9 done after busy", done, 1);
    if (erase) begin
      base = m_idx(p0) & ~63;
      for (int j = 0; j < 64; j++) mem_m[base + j] = 8'hFF;
    end else begin
      base = m_idx(p0) & ~7;
      for (int j = 0; j < 8; j++) mem_m[base + j] = mem_m[base + j] & lat_m[j];
    end
    for (int j = 0; j < 8; j++) lat_m[j] = 8'hFF;
    @(negedge clk);
    check("R9 done one cycle", done, 0);
    if (intrude) begin
      check("R11 no error from busy writes", wr_error, 0);
      read_reg(0, d); check("R11 pointer held during busy", d, ptr_m[7:0]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] d;
    void'($urandom(32'd2024));
    for (int i = 0; i < NB; i++) mem_m[i] = 8'hFF;
    for (int j = 0; j < 8; j++) lat_m[j] = 8'hFF;
    ptr_m = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    check("R1 busy", busy, 0); check("R1 done", done, 0); check("R1 werr", wr_error, 0);
    read_reg(0, d); check("R1 ptr lo", d, 0);
    read_reg(2, d); check("R1 ptr hi", d, 0);
    read_reg(3, d); check("R1 ctrl", d, 0);
    tr(0, "R1 array erased");

    // R3 table write does not touch the array
    set_ptr(22'h10); tw(0, 8'h5A);
    tr(0, "R3 array untouched by table write");

    // R12 rotation: decrement then eight post-increments
    set_ptr(22'h40);
    tr(2, "R2 post-decrement read");
    for (int k = 0; k < 8; k++) tw(1, 8'(8'h17 + k));
    read_reg(0, d); check("R12 pointer after writes", d, 8'h47);
    run_op(0, 0);
    peek(22'h47, "R12 first byte in latch 7");
    peek(22'h40, "R12 second byte in latch 0");
    check("R12 rotated byte value", mem_m[9'h47], 8'h17);

    // R12 neighbouring group: carry out of index 7
    set_ptr(22'h80);
    for (int k = 0; k < 8; k++) tw(1, 8'(8'h3C + k));
    run_op(0, 0);
    peek(22'h88, "R12 data in next group");
    peek(22'h80, "R12 intended group left erased");

    // R8 AND semantics
    set_ptr(22'h88); tw(0, 8'h0F);
    tw(0, 8'h0F); // same latch, plain mode keeps pointer
    run_op(0, 0);
    peek(22'h88, "R8 AND into array");
    set_ptr(22'h88); tw(0, 8'hFF); run_op(0, 0);
    peek(22'h88, "R8 one bit not restored");

    // R7 erase a row, R11 intrusions while busy
    set_ptr(22'h9A);
    run_op(1, 1);
    peek(22'h88, "R7 row byte erased");
    peek(22'hBF, "R7 row end erased");
    peek(22'h47, "R7 other row untouched");

    // R2 pre-increment read and R13 aliasing / wrap
    set_ptr(22'h40); tr(3, "R2 pre-increment read");
    read_reg(0, d); check("R2 pointer after pre-increment", d, 8'h41);
    peek(22'h240 | 22'h7, "R13 high pointer bits alias");
    set_ptr(22'h3FFFFF); tr(1, "R13 read at top of pointer");
    read_reg(2, d); check("R2 pointer wraps to zero", d, 0);

    // R5 broken sequences
    bus_wr(4, 8'h55); bus_wr(4, 8'h12);
    check("R5 wrong second key sets error", wr_error, 1);
    bus_wr(3, 8'h08);
    check("R5 error clears", wr_error, 0);
    bus_wr(4, 8'hAA); bus_wr(3, 8'h05);
    check("R5 start without unlock ignored", busy, 0);
    check("R5 start without unlock flags", wr_error, 1);
    bus_wr(3, 8'h08);
    bus_wr(4, 8'h55); bus_wr(4, 8'hAA); bus_wr(0, 8'h00); ptr_m[7:0] = 8'h00;
    check("R5 write after arming flags", wr_error, 1);
    bus_wr(3, 8'h05);
    check("R5 start after broken arm ignored", busy, 0);
    bus_wr(3, 8'h08);

    // R6 start without write-enable
    bus_wr(4, 8'h55); bus_wr(4, 8'hAA); bus_wr(3, 8'h04);
    check("R6 start without wren ignored", busy, 0);
    check("R6 start without wren flags", wr_error, 1);
    bus_wr(3, 8'h08);

    // R10 latches reset after completion: commit with no new writes changes nothing
    set_ptr(22'h100); tw(1, 8'h00); run_op(0, 0);
    set_ptr(22'h108); run_op(0, 0);
    peek(22'h108, "R10 latches back to FF");
    peek(22'h100, "R8 earlier commit landed");

    // random rounds
    for (int r = 0; r < 12; r++) begin
      set_ptr({$urandom_range(0, 63), 16'h0} | 22'($urandom_range(0, NB - 1)));
      for (int k = 0; k < 10; k++) begin
        int m; m = $urandom_range(0, 3);
        if ($urandom_range(0, 2) == 0) tr(m, "R2 random table read");
        else tw(m, 8'($urandom));
      end
      run_op($urandom_range(0, 4) == 0, 0);
      for (int k = 0; k < 4; k++) tr($urandom_range(0, 3), "R8 random readback");
    end

    summary();
  end
endmodule